// File: doc/BRIEF.md
# Sliding-Window Line Buffer Memory

This block sits between an external frame store and a two-dimensional convolution stage. It takes a raster-ordered stream of pixels through a valid/ready input. Each pixel it accepts is written once into a bank of on-chip row memories, and the block hands the convolution stage one vertical column of pixels per input pixel. Each column holds one pixel from each of the KERNEL most recent image rows. Because every image pixel crosses the external interface only once, the external read rate falls from KERNEL×KERNEL reads per output to one. The defaults are a 256×256 image, a 15×15 kernel and 8-bit pixels.

The bank holds KERNEL row memories. A rotating row pointer picks the memory that receives the incoming row, so the memory holding the oldest row is reused and no data is ever copied. Column output starts only once KERNEL-1 complete rows are stored. A separate window flag marks the columns where a full KERNEL×KERNEL window lies inside the image. Row-end and frame-end markers travel with each column. When the frame completes, the block stops accepting input until a frame-start pulse re-arms it. The same pulse also aborts a frame that is in progress.

Top module: `sliding_line_buffer`

## Requirements
- R1: After rst_ni is released, col_valid_o is 0 and pix_ready_o is 1.
- R2: While the first KERNEL-1 rows (rows 0 to KERNEL-2) of a frame are being received, no column is issued. win_valid_o is first 1 for the pixel at column KERNEL-1 of row KERNEL-1, which is accepted pixel number (KERNEL-1)*IMG_W+KERNEL of the frame.
- R3: For an accepted pixel at (x, y) with y >= KERNEL-1, the issued column carries pixel (x, y-KERNEL+1+j) in bits [j*PIX_W +: PIX_W], for j = 0 to KERNEL-1. Slot KERNEL-1 is the newest row.
- R4: Each accepted pixel of rows KERNEL-1 to IMG_H-1 produces exactly one column, in acceptance order. A frame therefore yields (IMG_H-KERNEL+1)*IMG_W columns, with no pixel dropped or used twice.
- R5: win_valid_o is 1 exactly when x >= KERNEL-1. This gives (IMG_W-KERNEL+1)*(IMG_H-KERNEL+1) windows per frame (242×242 at defaults).
- R6: row_end_o is 1 on the column with x = IMG_W-1. The column index then returns to 0. Row memories rotate, so column content stays correct over any number of rows.
- R7: While col_valid_o=1 and col_ready_i=0, pix_ready_o is 0 and col_data_o and col_valid_o hold their values.
- R8: frame_end_o is 1 on the column for the last pixel (IMG_W-1, IMG_H-1). From then on, pix_ready_o stays 0 until frame_start_i is asserted.
- R9: While frame_start_i is 1, pix_ready_o is 0. In the cycle after the pulse, col_valid_o is 0. The next accepted pixel is then taken as (0, 0) and the prefill of R2 starts again.
- R10: A cycle with pix_valid_i=0 accepts nothing, produces no column and does not advance the position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | Pulse that restarts the frame position and the prefill |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_data_i | input | PIX_W | Input pixel in raster order |
| pix_ready_o | output | 1 | Block can accept a pixel this cycle |
| col_valid_o | output | 1 | Column output valid |
| col_ready_i | input | 1 | Consumer takes the column this cycle |
| col_data_o | output | KERNEL*PIX_W | Column, slot 0 = oldest row |
| win_valid_o | output | 1 | Column completes a window that fits the image |
| row_end_o | output | 1 | Column is the last of its row |
| frame_end_o | output | 1 | Column is the last of the frame |

## Verification
The checker watches the handshake rules on every cycle. It checks that a stalled column holds its data, that no pixel is taken while the output is blocked, that the block goes quiet after the frame-end column, that a frame-start pulse gates the input and clears the output, and that the row and frame markers are consistent with each other. What only the bench's scenarios can show is the content itself: the bench checks every column pixel by pixel against the raster position it should carry, across row-memory rotation, input gaps, output stalls and a frame aborted mid-way. It also checks the prefill length and the per-frame column and window totals.

// File: rtl/lb_pkg.sv
package lb_pkg;
  typedef struct packed {
    logic win;
    logic row_end;
    logic frame_end;
  } col_tag_t;
endpackage

// File: rtl/lb_line_mem.sv
module lb_line_mem #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  // read-before-write; the written line's read data is never used
  always_ff @(posedge clk_i) begin
    if (en_i) begin
      rdata_o <= mem_q[addr_i];
      if (we_i) mem_q[addr_i] <= wdata_i;
    end
  end
endmodule

// File: rtl/lb_raster_ctrl.sv
module lb_raster_ctrl
  import lb_pkg::*;
#(
  parameter int IMG_W  = 256,
  parameter int IMG_H  = 256,
  parameter int KERNEL = 15,
  localparam int XW    = $clog2(IMG_W),
  localparam int YW    = $clog2(IMG_H),
  localparam int LW    = (KERNEL > 1) ? $clog2(KERNEL) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_start_i,
  input  logic          accept_i,
  output logic [XW-1:0] x_o,
  output logic [LW-1:0] wr_line_o,
  output logic          emit_o,
  output logic          done_o,
  output col_tag_t      tag_o
);
  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;
  logic [LW-1:0] line_q;
  logic          done_q;
  logic          x_last, y_last;

  assign x_last = (x_q == XW'(IMG_W - 1));
  assign y_last = (y_q == YW'(IMG_H - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q    <= '0;
      y_q    <= '0;
      line_q <= '0;
      done_q <= 1'b0;
    end else if (frame_start_i) begin
      x_q    <= '0;
      y_q    <= '0;
      line_q <= '0;
      done_q <= 1'b0;
    end else if (accept_i) begin
      if (x_last) begin
        x_q <= '0;
        if (y_last) begin
          y_q    <= '0;
          line_q <= '0;
          done_q <= 1'b1;
        end else begin
          y_q    <= y_q + 1'b1;
          // oldest line becomes the next write target
          line_q <= (line_q == LW'(KERNEL - 1)) ? '0 : line_q + 1'b1;
        end
      end else begin
        x_q <= x_q + 1'b1;
      end
    end
  end

  assign x_o       = x_q;
  assign wr_line_o = line_q;
  assign done_o    = done_q;
  assign emit_o    = (y_q >= YW'(KERNEL - 1));

  always_comb begin
    tag_o.win       = emit_o && (x_q >= XW'(KERNEL - 1));
    tag_o.row_end   = x_last;
    tag_o.frame_end = x_last && y_last;
  end
endmodule

// File: rtl/lb_col_align.sv
module lb_col_align
  import lb_pkg::*;
#(
  parameter int KERNEL = 15,
  parameter int DW     = 8,
  localparam int LW    = (KERNEL > 1) ? $clog2(KERNEL) : 1,
  localparam int CW    = KERNEL * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_start_i,
  input  logic          accept_i,
  input  logic          emit_i,
  input  logic [LW-1:0] line_i,
  input  logic [DW-1:0] pix_i,
  input  col_tag_t      tag_i,
  input  logic [CW-1:0] rd_i,
  input  logic          col_ready_i,
  output logic          col_valid_o,
  output logic [CW-1:0] col_data_o,
  output col_tag_t      tag_o
);
  logic          valid_q;
  logic [LW-1:0] line_q;
  logic [DW-1:0] pix_q;
  col_tag_t      tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
    end else if (frame_start_i) begin
      valid_q <= 1'b0;
    end else if (accept_i) begin
      valid_q <= emit_i;
    end else if (col_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      pix_q  <= '0;
      tag_q  <= '0;
    end else if (accept_i) begin
      line_q <= line_i;
      pix_q  <= pix_i;
      tag_q  <= tag_i;
    end
  end

  // slot j takes row y-KERNEL+1+j, stored in line (wr_line+1+j) mod KERNEL
  always_comb begin
    for (int j = 0; j < KERNEL - 1; j++) begin
      automatic int src = int'(line_q) + 1 + j;
      if (src >= KERNEL) src = src - KERNEL;
      col_data_o[j*DW +: DW] = rd_i[src*DW +: DW];
    end
    col_data_o[(KERNEL-1)*DW +: DW] = pix_q;
  end

  assign col_valid_o     = valid_q;
  assign tag_o.win       = valid_q && tag_q.win;
  assign tag_o.row_end   = valid_q && tag_q.row_end;
  assign tag_o.frame_end = valid_q && tag_q.frame_end;
endmodule

// File: rtl/sliding_line_buffer.sv
module sliding_line_buffer
  import lb_pkg::*;
#(
  parameter int IMG_W  = 256,
  parameter int IMG_H  = 256,
  parameter int KERNEL = 15,
  parameter int PIX_W  = 8,
  localparam int XW    = $clog2(IMG_W),
  localparam int LW    = (KERNEL > 1) ? $clog2(KERNEL) : 1,
  localparam int CW    = KERNEL * PIX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_data_i,
  output logic             pix_ready_o,
  output logic             col_valid_o,
  input  logic             col_ready_i,
  output logic [CW-1:0]    col_data_o,
  output logic             win_valid_o,
  output logic             row_end_o,
  output logic             frame_end_o
);
  logic          accept;
  logic          done;
  logic          emit;
  logic [XW-1:0] x_addr;
  logic [LW-1:0] wr_line;
  col_tag_t      tag_in, tag_out;
  logic [CW-1:0] rd_bus;

  assign pix_ready_o = !done && !frame_start_i && (!col_valid_o || col_ready_i);
  assign accept      = pix_valid_i && pix_ready_o;

  lb_raster_ctrl #(
    .IMG_W (IMG_W),
    .IMG_H (IMG_H),
    .KERNEL(KERNEL)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(frame_start_i),
    .accept_i     (accept),
    .x_o          (x_addr),
    .wr_line_o    (wr_line),
    .emit_o       (emit),
    .done_o       (done),
    .tag_o        (tag_in)
  );

  for (genvar i = 0; i < KERNEL; i++) begin : g_line
    lb_line_mem #(
      .DEPTH(IMG_W),
      .DW   (PIX_W)
    ) u_mem (
      .clk_i  (clk_i),
      .en_i   (accept),
      .we_i   (accept && (wr_line == LW'(i))),
      .addr_i (x_addr),
      .wdata_i(pix_data_i),
      .rdata_o(rd_bus[i*PIX_W +: PIX_W])
    );
  end

  lb_col_align #(
    .KERNEL(KERNEL),
    .DW    (PIX_W)
  ) u_align (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(frame_start_i),
    .accept_i     (accept),
    .emit_i       (emit),
    .line_i       (wr_line),
    .pix_i        (pix_data_i),
    .tag_i        (tag_in),
    .rd_i         (rd_bus),
    .col_ready_i  (col_ready_i),
    .col_valid_o  (col_valid_o),
    .col_data_o   (col_data_o),
    .tag_o        (tag_out)
  );

  assign win_valid_o = tag_out.win;
  assign row_end_o   = tag_out.row_end;
  assign frame_end_o = tag_out.frame_end;
endmodule

// File: rtl/sliding_line_buffer_chk.sv
module sliding_line_buffer_chk #(
  parameter int CW = 120
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          frame_start_i,
  input logic          pix_valid_i,
  input logic          pix_ready_o,
  input logic          col_valid_o,
  input logic          col_ready_i,
  input logic [CW-1:0] col_data_o,
  input logic          win_valid_o,
  input logic          row_end_o,
  input logic          frame_end_o
);
  a_r7_hold_column: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_valid_o && !col_ready_i && !frame_start_i) |=> (col_valid_o && $stable(col_data_o)));

  a_r7_no_take_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_valid_o && !col_ready_i) |-> !pix_ready_o);

  a_r8_quiet_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_valid_o && frame_end_o) |-> !pix_ready_o);

  a_r8_end_on_row_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |-> row_end_o);

  a_r9_start_gates_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |-> !pix_ready_o);

  a_r9_start_clears_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> !col_valid_o);

  a_r6_row_end_is_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_end_o |-> (col_valid_o && win_valid_o));

  a_r5_window_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> col_valid_o);
endmodule

bind sliding_line_buffer sliding_line_buffer_chk #(.CW(KERNEL * PIX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_start_i(frame_start_i),
  .pix_valid_i  (pix_valid_i),
  .pix_ready_o  (pix_ready_o),
  .col_valid_o  (col_valid_o),
  .col_ready_i  (col_ready_i),
  .col_data_o   (col_data_o),
  .win_valid_o  (win_valid_o),
  .row_end_o    (row_end_o),
  .frame_end_o  (frame_end_o)
);

// File: tb/sliding_line_buffer_bench.sv
module sliding_line_buffer_bench;
  localparam int W  = 20;
  localparam int H  = 18;
  localparam int K  = 5;
  localparam int DW = 8;
  localparam int CW = K * DW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          frame_start_i = 1'b0;
  logic          pix_valid_i = 1'b0;
  logic [DW-1:0] pix_data_i = '0;
  logic          pix_ready_o;
  logic          col_valid_o;
  logic          col_ready_i = 1'b1;
  logic [CW-1:0] col_data_o;
  logic          win_valid_o, row_end_o, frame_end_o;

  int n_checks = 0;
  int n_fail   = 0;

  int mon_on = 0, mon_salt = 0, mon_idx = 0, mon_win = 0, mon_rows = 0, mon_first_win = -1;
  logic          prev_stall = 1'b0;
  logic [CW-1:0] prev_data;

  sliding_line_buffer #(
    .IMG_W (W),
    .IMG_H (H),
    .KERNEL(K),
    .PIX_W (DW)
  ) u_sliding_line_buffer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(frame_start_i),
    .pix_valid_i  (pix_valid_i),
    .pix_data_i   (pix_data_i),
    .pix_ready_o  (pix_ready_o),
    .col_valid_o  (col_valid_o),
    .col_ready_i  (col_ready_i),
    .col_data_o   (col_data_o),
    .win_valid_o  (win_valid_o),
    .row_end_o    (row_end_o),
    .frame_end_o  (frame_end_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic logic [DW-1:0] pix(int x, int y, int salt);
    return DW'(x * 7 + y * 13 + salt * 29 + 3);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (mon_on != 0) begin
      if (prev_stall) begin
        chk(col_valid_o && col_data_o == prev_data, "R7", "held column",
            longint'(col_data_o), longint'(prev_data));
      end
      if (col_valid_o && !col_ready_i)
        chk(!pix_ready_o, "R7", "ready during stall", pix_ready_o, 0);
      prev_stall = col_valid_o && !col_ready_i && !frame_start_i;
      prev_data  = col_data_o;
      if (col_valid_o && col_ready_i) begin
        automatic int ex = mon_idx % W;
        automatic int ey = K - 1 + mon_idx / W;
        automatic logic [CW-1:0] exp_col;
        for (int j = 0; j < K; j++) exp_col[j*DW +: DW] = pix(ex, ey - K + 1 + j, mon_salt);
        chk(col_data_o == exp_col, "R3", "column content", longint'(col_data_o), longint'(exp_col));
        chk(win_valid_o == (ex >= K - 1), "R5", "window flag", win_valid_o, (ex >= K - 1));
        chk(row_end_o == (ex == W - 1), "R6", "row end flag", row_end_o, (ex == W - 1));
        chk(frame_end_o == (ex == W - 1 && ey == H - 1), "R8", "frame end flag", frame_end_o,
            (ex == W - 1 && ey == H - 1));
        if (win_valid_o) begin
          mon_win++;
          if (mon_first_win < 0) mon_first_win = mon_idx;
        end
        if (row_end_o) mon_rows++;
        mon_idx++;
      end
    end
  end

  task automatic mon_restart(int salt);
    mon_salt = salt; mon_idx = 0; mon_win = 0; mon_rows = 0; mon_first_win = -1;
    prev_stall = 1'b0; mon_on = 1;
  endtask

  // vmode: gaps on pix_valid_i (R10); rmode: consumer stalls (R7)
  task automatic run_stream(int salt, int count, int vmode, int rmode);
    int idx = 0;
    int cyc = 0;
    while (idx < count) begin
      @(posedge clk_i); #1;
      pix_valid_i = (vmode != 0) ? (cyc % 4 != 1) : 1'b1;
      pix_data_i  = pix(idx % W, idx / W, salt);
      col_ready_i = (rmode != 0) ? (cyc % 3 != 0) : 1'b1;
      cyc++;
      @(negedge clk_i);
      if (pix_valid_i && pix_ready_o) idx++;
    end
    @(posedge clk_i); #1;
    pix_valid_i = 1'b0;
    col_ready_i = 1'b1;
    repeat (4) @(posedge clk_i);
  endtask

  task automatic pulse_start();
    @(posedge clk_i); #1;
    frame_start_i = 1'b1;
    @(negedge clk_i);
    chk(!pix_ready_o, "R9", "ready during frame start", pix_ready_o, 0);
    @(posedge clk_i); #1;
    frame_start_i = 1'b0;
    @(negedge clk_i);
    chk(!col_valid_o, "R9", "valid after frame start", col_valid_o, 0);
    chk(pix_ready_o, "R9", "ready after frame start", pix_ready_o, 1);
  endtask

  task automatic check_frame_totals(string tag);
    chk(mon_idx == (H - K + 1) * W, "R4", {tag, " column count"}, mon_idx, (H - K + 1) * W);
    chk(mon_win == (W - K + 1) * (H - K + 1), "R5", {tag, " window count"}, mon_win,
        (W - K + 1) * (H - K + 1));
    chk(mon_rows == H - K + 1, "R6", {tag, " row count"}, mon_rows, H - K + 1);
    chk(mon_first_win == K - 1, "R2", {tag, " first window index"}, mon_first_win, K - 1);
  endtask

  task automatic t_reset();
    #5;
    chk(!col_valid_o, "R1", "valid in reset", col_valid_o, 0);
    #30 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!col_valid_o, "R1", "valid after reset", col_valid_o, 0);
    chk(pix_ready_o, "R1", "ready after reset", pix_ready_o, 1);
  endtask

  task automatic t_prefill_silent();
    // R2: nothing emitted while rows 0..K-2 arrive
    mon_restart(1);
    run_stream(1, (K - 1) * W, 0, 0);
    chk(mon_idx == 0, "R2", "columns during prefill", mon_idx, 0);
    pulse_start();
  endtask

  task automatic t_plain_frame();
    mon_restart(2);
    run_stream(2, W * H, 0, 0);
    check_frame_totals("plain");
  endtask

  task automatic t_blocked_after_end();
    int seen = 0;
    @(posedge clk_i); #1;
    pix_valid_i = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      if (pix_ready_o || col_valid_o) seen++;
    end
    chk(seen == 0, "R8", "input blocked after frame end", seen, 0);
    @(posedge clk_i); #1;
    pix_valid_i = 1'b0;
    pulse_start();
  endtask

  task automatic t_gaps_and_stalls();
    mon_restart(3);
    run_stream(3, W * H, 1, 1);
    check_frame_totals("stall");
    chk(mon_idx == (H - K + 1) * W, "R10", "gaps add no columns", mon_idx, (H - K + 1) * W);
    pulse_start();
  endtask

  task automatic t_abort_restart();
    mon_restart(4);
    run_stream(4, (K - 1) * W + W / 2 + 1, 0, 1);
    chk(mon_idx == W / 2 + 1, "R9", "partial frame columns", mon_idx, W / 2 + 1);
    pulse_start();
    mon_restart(5);
    run_stream(5, W * H, 0, 0);
    check_frame_totals("restart");
  endtask

  initial begin
    t_reset();
    t_prefill_silent();
    t_plain_frame();
    t_blocked_after_end();
    t_gaps_and_stalls();
    t_abort_restart();
    mon_on = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule